// File: doc/BRIEF.md
# Bit-Field Extract and Insert Execution Unit

This execution unit sits in a 64-bit integer pipeline and handles one family of instructions: bit-field extraction, bit-field insertion, byte and halfword reordering, and sign extension of a byte or halfword. Each issued operation gives the unit a 32-bit instruction word, two 64-bit source operands (first source `src_s` and second source `src_t`) and a flag that enables 64-bit operation. On the clock edge after the issue strobe, the unit presents the 64-bit result, a register write enable, the destination register index and a reserved-instruction flag.

Field positions are taken from the instruction itself. Extract variants take a start position and a width minus one. Insert variants take the lowest and highest bit of the target range. Three 64-bit variants of each, extract and insert, move the start, the end or both up by 32 so that fields anywhere in a doubleword can be reached. Operations that work on 32 bits sign-extend their 32-bit result to 64 bits.

Top module: `bitfield_unit`

## Requirements
- R1: Instruction fields are: major opcode [31:26], first source index [25:21], second source index [20:16], size/high/rd field [15:11], low field [10:6], function [5:0]. The unit accepts only major opcode 6'b011111. Any other opcode raises the reserved flag and clears the write enable.
- R2: Function 6'b000000 takes the bits of `src_s[31:0]` from position low upward, width high+1 (bits past 31 read as zero), zero-extends them to 32 bits, then sign-extends that value from bit 31 to 64 bits.
- R3: Function 6'b000011 extracts width high+1 starting at low. Function 6'b000001 extracts width high+33 starting at low. Function 6'b000010 extracts width high+1 starting at low+32. All three take the field from `src_s` and zero-fill the upper result bits.
- R4: Functions 6'b000100 (32-bit) and 6'b000111 (64-bit) replace bits low..high of `src_t` with `src_s` shifted left by low. This happens only when low <= high; otherwise the result is `src_t` unchanged. The 32-bit form sign-extends bit 31 of the merged value.
- R5: Function 6'b000101 inserts over range low..high+32. Function 6'b000110 inserts over range low+32..high+32 with `src_s` shifted left by low+32, and leaves `src_t` unchanged when low > high.
- R6: Function 6'b100000 picks its operation from field [10:6]. Value 5'b00010 swaps the two bytes of each halfword of `src_t[31:0]` and sign-extends the result. Value 5'b10000 sign-extends `src_t[7:0]`. Value 5'b11000 sign-extends `src_t[15:0]`.
- R7: Function 6'b100100 picks its operation from field [10:6]. Value 5'b00010 swaps the bytes inside each of the four halfwords of `src_t`. Value 5'b00101 reverses the order of the four halfwords.
- R8: The 64-bit forms (functions 000001, 000010, 000011, 000101, 000110, 000111 and 100100) raise the reserved flag with the write enable low and a zero result when `wide_en` is 0. The 32-bit forms are accepted whatever the value of `wide_en`.
- R9: An undefined function code, or an undefined [10:6] code in either reorder group, raises the reserved flag. The write enable and the reserved flag are never high together.
- R10: The destination index is the second source index [20:16] for extract and insert, and field [15:11] for the reorder and sign-extend groups.
- R11: Result, write enable, destination and flag appear on the edge after `op_valid`. In a cycle without `op_valid`, the write enable and the flag go low on the next edge while the result and the destination hold.
- R12: A synchronous active-low reset clears the result, the destination, the write enable and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Issue strobe for this cycle's operation |
| instr | input | 32 | Instruction word |
| src_s | input | 64 | First source operand value |
| src_t | input | 64 | Second source operand value (insert target, reorder input) |
| wide_en | input | 1 | 64-bit operation enabled |
| res_q | output | 64 | Registered result |
| wr_en_q | output | 1 | Registered register write enable |
| dest_q | output | 5 | Registered destination register index |
| rsvd_q | output | 1 | Registered reserved-instruction flag |

## Verification
The assertions assume that `instr`, `src_s`, `src_t` and `wide_en` hold known values whenever `op_valid` is high, and that reset is held low for at least one edge before the first issue. The stimulus changes inputs only on falling edges and raises `op_valid` only after reset is released. The sign-extension and destination properties test only encodings that the decoder accepts, so every table row that drives those encodings uses `wide_en` values under which they are legal.

// File: rtl/bfu_pkg.sv
// Shared definitions for the bit-field unit: datapath widths, opcode and
// function encodings, and the internal operation enumeration.
// Assumes a 64-bit datapath made of two 32-bit words.
package bfu_pkg;
    localparam int XLEN   = 64;
    localparam int WORD   = XLEN / 2;
    localparam int HALFW  = 16;
    localparam int NHALF  = XLEN / HALFW;
    localparam int POS_W  = $clog2(XLEN) + 1;
    localparam int REG_W  = 5;

    localparam logic [5:0] OPC_SPECIAL3 = 6'b011111;
    localparam logic [5:0] FN_EXT   = 6'b000000;
    localparam logic [5:0] FN_DEXTM = 6'b000001;
    localparam logic [5:0] FN_DEXTU = 6'b000010;
    localparam logic [5:0] FN_DEXT  = 6'b000011;
    localparam logic [5:0] FN_INS   = 6'b000100;
    localparam logic [5:0] FN_DINSM = 6'b000101;
    localparam logic [5:0] FN_DINSU = 6'b000110;
    localparam logic [5:0] FN_DINS  = 6'b000111;
    localparam logic [5:0] FN_SHUF32 = 6'b100000;
    localparam logic [5:0] FN_SHUF64 = 6'b100100;
    localparam logic [4:0] SA_WSBH = 5'b00010;
    localparam logic [4:0] SA_SEB  = 5'b10000;
    localparam logic [4:0] SA_SEH  = 5'b11000;
    localparam logic [4:0] SA_DSBH = 5'b00010;
    localparam logic [4:0] SA_DSHD = 5'b00101;

    typedef enum logic [3:0] {
        OP_NONE, OP_EXT, OP_DEXT, OP_DEXTM, OP_DEXTU,
        OP_INS, OP_DINS, OP_DINSM, OP_DINSU,
        OP_WSBH, OP_SEB, OP_SEH, OP_DSBH, OP_DSHD
    } bfu_op_e;
endpackage

// File: rtl/bfu_decode.sv
// Instruction decoder: maps the instruction word to an internal operation,
// marks 64-bit forms, picks the destination index and judges legality.
// Assumes instr is stable while op_valid is high; purely combinational.
module bfu_decode
    import bfu_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic             wide_en,
    output bfu_op_e          op,
    output logic [REG_W-1:0] dest,
    output logic             legal
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic [4:0] sa;
    logic       is_wide;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];
    assign sa  = instr[10:6];

    // Operation and destination selection from opcode, function and sa.
    always_comb begin
        op   = OP_NONE;
        dest = instr[20:16];
        if (opc == OPC_SPECIAL3) begin
            case (fn)
                FN_EXT:   op = OP_EXT;
                FN_DEXT:  op = OP_DEXT;
                FN_DEXTM: op = OP_DEXTM;
                FN_DEXTU: op = OP_DEXTU;
                FN_INS:   op = OP_INS;
                FN_DINS:  op = OP_DINS;
                FN_DINSM: op = OP_DINSM;
                FN_DINSU: op = OP_DINSU;
                FN_SHUF32: begin
                    dest = instr[15:11];
                    case (sa)
                        SA_WSBH: op = OP_WSBH;
                        SA_SEB:  op = OP_SEB;
                        SA_SEH:  op = OP_SEH;
                        default: op = OP_NONE;
                    endcase
                end
                FN_SHUF64: begin
                    dest = instr[15:11];
                    case (sa)
                        SA_DSBH: op = OP_DSBH;
                        SA_DSHD: op = OP_DSHD;
                        default: op = OP_NONE;
                    endcase
                end
                default: op = OP_NONE;
            endcase
        end
    end

    // Classifies the 64-bit-only forms.
    always_comb begin
        case (op)
            OP_DEXT, OP_DEXTM, OP_DEXTU, OP_DINS, OP_DINSM, OP_DINSU,
            OP_DSBH, OP_DSHD: is_wide = 1'b1;
            default:          is_wide = 1'b0;
        endcase
    end

    assign legal = (op != OP_NONE) && (!is_wide || wide_en);
endmodule

// File: rtl/bfu_field.sv
// Field extract/insert datapath: one shared right-shift-and-mask for all
// extract forms and one shared range-merge for all insert forms.
// Assumes lsb/fsz come straight from instruction bits [10:6]/[15:11].
module bfu_field
    import bfu_pkg::*;
(
    input  bfu_op_e          op,
    input  logic [4:0]       lsb,
    input  logic [4:0]       fsz,
    input  logic [XLEN-1:0]  src_s,
    input  logic [XLEN-1:0]  src_t,
    output logic [XLEN-1:0]  result
);
    localparam logic [POS_W-1:0] OFS  = POS_W'(WORD);
    localparam logic [POS_W-1:0] TOP  = POS_W'(XLEN - 1);
    localparam logic [POS_W-1:0] FULL = POS_W'(XLEN);

    logic [POS_W-1:0] lsb_w, fsz_w;
    logic [POS_W-1:0] ex_lo, ex_w, in_lo, in_hi;
    logic [XLEN-1:0]  ex_src, ex_mask, ex_val;
    logic [XLEN-1:0]  in_mask, in_val;
    logic             in_ok;

    assign lsb_w = POS_W'(lsb);
    assign fsz_w = POS_W'(fsz);

    // Start position, width and source word for the extract forms.
    always_comb begin
        ex_src = src_s;
        ex_lo  = lsb_w;
        ex_w   = fsz_w + 1'b1;
        case (op)
            OP_EXT:   ex_src = {{WORD{1'b0}}, src_s[WORD-1:0]};
            OP_DEXTM: ex_w   = fsz_w + OFS + 1'b1;
            OP_DEXTU: ex_lo  = lsb_w + OFS;
            default:  ;
        endcase
    end

    assign ex_mask = (ex_w >= FULL) ? {XLEN{1'b1}}
                                    : ((XLEN'(1) << ex_w) - XLEN'(1));
    assign ex_val  = (ex_src >> ex_lo) & ex_mask;

    // Low and high bit of the insert range for each insert form.
    always_comb begin
        in_lo = lsb_w;
        in_hi = fsz_w;
        case (op)
            OP_DINSM: in_hi = fsz_w + OFS;
            OP_DINSU: begin
                in_lo = lsb_w + OFS;
                in_hi = fsz_w + OFS;
            end
            default:  ;
        endcase
    end

    assign in_ok   = (in_lo <= in_hi);
    assign in_mask = ({XLEN{1'b1}} << in_lo) & ({XLEN{1'b1}} >> (TOP - in_hi));
    assign in_val  = src_t ^ ((src_t ^ (src_s << in_lo)) & in_mask);

    // Final per-operation result including 32-bit sign extension.
    always_comb begin
        case (op)
            OP_EXT:   result = {{WORD{ex_val[WORD-1]}}, ex_val[WORD-1:0]};
            OP_DEXT, OP_DEXTM, OP_DEXTU: result = ex_val;
            OP_INS:   result = in_ok ? {{WORD{in_val[WORD-1]}}, in_val[WORD-1:0]}
                                     : src_t;
            OP_DINS, OP_DINSM, OP_DINSU: result = in_ok ? in_val : src_t;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/bfu_shuffle.sv
// Byte/halfword reorder and sign-extend datapath working on the second
// source operand. Assumes op is one of the reorder operations when used.
module bfu_shuffle
    import bfu_pkg::*;
(
    input  bfu_op_e          op,
    input  logic [XLEN-1:0]  src_t,
    output logic [XLEN-1:0]  result
);
    logic [XLEN-1:0] bswap;
    logic [XLEN-1:0] hrev;

    // One byte swap and one halfword slot mapping per halfword lane.
    for (genvar g = 0; g < NHALF; g++) begin : g_lane
        assign bswap[g*HALFW +: HALFW] = {src_t[g*HALFW +: 8], src_t[g*HALFW+8 +: 8]};
        assign hrev[g*HALFW +: HALFW]  = src_t[(NHALF-1-g)*HALFW +: HALFW];
    end

    // Select the reorder result for the decoded operation.
    always_comb begin
        case (op)
            OP_WSBH: result = {{WORD{bswap[WORD-1]}}, bswap[WORD-1:0]};
            OP_SEB:  result = {{(XLEN-8){src_t[7]}}, src_t[7:0]};
            OP_SEH:  result = {{(XLEN-HALFW){src_t[HALFW-1]}}, src_t[HALFW-1:0]};
            OP_DSBH: result = bswap;
            OP_DSHD: result = hrev;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
// Top level of the bit-field execution unit: decodes the instruction,
// runs the field and reorder datapaths, and registers result, write
// enable, destination and reserved flag one edge after op_valid.
// Assumes a synchronous active-low reset held for at least one edge.
module bitfield_unit
    import bfu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [31:0]      instr,
    input  logic [63:0]      src_s,
    input  logic [63:0]      src_t,
    input  logic             wide_en,
    output logic [63:0]      res_q,
    output logic             wr_en_q,
    output logic [4:0]       dest_q,
    output logic             rsvd_q
);
    bfu_op_e          op;
    logic [REG_W-1:0] dest;
    logic             legal;
    logic [XLEN-1:0]  field_res, shuf_res, res_d;
    logic             is_shuf;

    bfu_decode u_dec (
        .instr   (instr),
        .wide_en (wide_en),
        .op      (op),
        .dest    (dest),
        .legal   (legal)
    );

    bfu_field u_field (
        .op     (op),
        .lsb    (instr[10:6]),
        .fsz    (instr[15:11]),
        .src_s  (src_s),
        .src_t  (src_t),
        .result (field_res)
    );

    bfu_shuffle u_shuf (
        .op     (op),
        .src_t  (src_t),
        .result (shuf_res)
    );

    // Route the reorder group to the shuffle path, the rest to the field path.
    always_comb begin
        case (op)
            OP_WSBH, OP_SEB, OP_SEH, OP_DSBH, OP_DSHD: is_shuf = 1'b1;
            default:                                   is_shuf = 1'b0;
        endcase
        res_d = legal ? (is_shuf ? shuf_res : field_res) : '0;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            wr_en_q <= 1'b0;
            dest_q  <= '0;
            rsvd_q  <= 1'b0;
        end else begin
            wr_en_q <= op_valid && legal;
            rsvd_q  <= op_valid && !legal;
            if (op_valid) begin
                res_q  <= res_d;
                dest_q <= dest;
            end
        end
    end
endmodule

// File: rtl/bfu_checker.sv
// Property checker for bitfield_unit, attached with bind. Assumes inputs
// are known while op_valid is high and reset is asserted at start.
module bfu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [31:0] instr,
    input logic        wide_en,
    input logic [63:0] res_q,
    input logic        wr_en_q,
    input logic [4:0]  dest_q,
    input logic        rsvd_q
);
    logic is_s3, wide_fn, shuf_fn, seb_enc, ext_enc;
    assign is_s3   = (instr[31:26] == 6'b011111);
    assign wide_fn = (instr[5:3] == 3'b000 && instr[1:0] != 2'b00) || instr[5:0] == 6'b100100;
    assign shuf_fn = instr[5:0] == 6'b100000 || instr[5:0] == 6'b100100;
    assign seb_enc = is_s3 && instr[5:0] == 6'b100000 && instr[10:6] == 5'b10000;
    assign ext_enc = is_s3 && instr[5:0] == 6'b000000;

    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (res_q == 64'd0 && !wr_en_q && !rsvd_q && dest_q == 5'd0));

    assert_foreign_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_s3) |=> (rsvd_q && !wr_en_q));

    assert_ext_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ext_enc) |=> (wr_en_q && res_q[63:32] == {32{res_q[31]}}));

    assert_seb_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && seb_enc) |=> (wr_en_q && res_q[63:8] == {56{res_q[7]}}));

    assert_wide_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_s3 && wide_fn && !wide_en) |=> (rsvd_q && !wr_en_q && res_q == 64'd0));

    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_q && rsvd_q));

    assert_shuf_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_s3 && shuf_fn) |=> (dest_q == $past(instr[15:11])));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wr_en_q && !rsvd_q && $stable(res_q) && $stable(dest_q)));
endmodule

bind bitfield_unit bfu_checker u_bfu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .instr    (instr),
    .wide_en  (wide_en),
    .res_q    (res_q),
    .wr_en_q  (wr_en_q),
    .dest_q   (dest_q),
    .rsvd_q   (rsvd_q)
);

// File: tb/tb_bitfield_unit.sv
// Self-checking bench: walks a vector table, then directed reset and idle tests.
module tb_bitfield_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_s = '0;
    logic [63:0] src_t = '0;
    logic        wide_en = 1'b0;
    logic [63:0] res_q;
    logic        wr_en_q;
    logic [4:0]  dest_q;
    logic        rsvd_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bitfield_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
        .src_s(src_s), .src_t(src_t), .wide_en(wide_en),
        .res_q(res_q), .wr_en_q(wr_en_q), .dest_q(dest_q), .rsvd_q(rsvd_q)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] a,
                                       input logic [4:0] b, input logic [4:0] c,
                                       input logic [4:0] d, input logic [5:0] fn);
        return {opc, a, b, c, d, fn};
    endfunction

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] ins;
        logic [63:0] s;
        logic [63:0] t;
        logic        wide;
        logic [63:0] res;
        logic        we;
        logic        rsvd;
        logic [4:0]  dest;
    } vec_t;

    localparam logic [5:0]  S3 = 6'b011111;
    localparam logic [63:0] VS = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VT = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] VB = 64'h0000_0000_0000_8080;
    localparam int NV = 23;

    localparam vec_t VECS [NV] = '{
        '{4'd2,  mk(S3,1,2,7,4,6'b000000),  VS, VT, 1'b1, 64'h0000_0000_0000_00DE, 1'b1, 1'b0, 5'd2},  // R2 narrow field
        '{4'd2,  mk(S3,1,2,31,0,6'b000000), VS, VT, 1'b1, 64'hFFFF_FFFF_89AB_CDEF, 1'b1, 1'b0, 5'd2},  // R2 full word sext
        '{4'd3,  mk(S3,1,2,15,8,6'b000011), VS, VT, 1'b1, 64'h0000_0000_0000_ABCD, 1'b1, 1'b0, 5'd2},  // R3 DEXT
        '{4'd3,  mk(S3,1,2,3,4,6'b000001),  VS, VT, 1'b1, 64'h0000_0006_789A_BCDE, 1'b1, 1'b0, 5'd2},  // R3 DEXTM
        '{4'd3,  mk(S3,1,2,15,0,6'b000010), VS, VT, 1'b1, 64'h0000_0000_0000_4567, 1'b1, 1'b0, 5'd2},  // R3 DEXTU
        '{4'd4,  mk(S3,1,2,15,8,6'b000100), VS, VT, 1'b0, 64'h0000_0000_7654_EF10, 1'b1, 1'b0, 5'd2},  // R4 INS
        '{4'd4,  mk(S3,1,2,3,9,6'b000100),  VS, VT, 1'b0, VT,                      1'b1, 1'b0, 5'd2},  // R4 inverted
        '{4'd4,  mk(S3,1,2,31,28,6'b000100),VS, VT, 1'b0, 64'hFFFF_FFFF_F654_3210, 1'b1, 1'b0, 5'd2},  // R4 sign bit set
        '{4'd4,  mk(S3,1,2,7,0,6'b000111),  VS, VT, 1'b1, 64'hFEDC_BA98_7654_32EF, 1'b1, 1'b0, 5'd2},  // R4 DINS
        '{4'd5,  mk(S3,1,2,15,16,6'b000101),VS, VT, 1'b1, 64'hFEDC_89AB_CDEF_3210, 1'b1, 1'b0, 5'd2},  // R5 DINSM
        '{4'd5,  mk(S3,1,2,7,0,6'b000110),  VS, VT, 1'b1, 64'hFEDC_BAEF_7654_3210, 1'b1, 1'b0, 5'd2},  // R5 DINSU
        '{4'd5,  mk(S3,1,2,2,5,6'b000110),  VS, VT, 1'b1, VT,                      1'b1, 1'b0, 5'd2},  // R5 inverted
        '{4'd6,  mk(S3,0,2,7,2,6'b100000),  VS, VT, 1'b0, 64'h0000_0000_5476_1032, 1'b1, 1'b0, 5'd7},  // R6 WSBH, R10 dest
        '{4'd6,  mk(S3,0,2,9,16,6'b100000), VS, VB, 1'b0, 64'hFFFF_FFFF_FFFF_FF80, 1'b1, 1'b0, 5'd9},  // R6 SEB
        '{4'd6,  mk(S3,0,2,9,24,6'b100000), VS, VB, 1'b0, 64'hFFFF_FFFF_FFFF_8080, 1'b1, 1'b0, 5'd9},  // R6 SEH
        '{4'd7,  mk(S3,0,2,11,2,6'b100100), VS, VT, 1'b1, 64'hDCFE_98BA_5476_1032, 1'b1, 1'b0, 5'd11}, // R7 DSBH
        '{4'd7,  mk(S3,0,2,12,5,6'b100100), VS, VT, 1'b1, 64'h3210_7654_BA98_FEDC, 1'b1, 1'b0, 5'd12}, // R7 DSHD
        '{4'd8,  mk(S3,1,2,15,8,6'b000011), VS, VT, 1'b0, 64'd0,                   1'b0, 1'b1, 5'd2},  // R8 DEXT gated
        '{4'd8,  mk(S3,0,2,12,5,6'b100100), VS, VT, 1'b0, 64'd0,                   1'b0, 1'b1, 5'd12}, // R8 DSHD gated
        '{4'd8,  mk(S3,1,2,31,0,6'b000000), VS, VT, 1'b0, 64'hFFFF_FFFF_89AB_CDEF, 1'b1, 1'b0, 5'd2},  // R8 EXT still legal
        '{4'd9,  mk(S3,1,2,3,3,6'b001000),  VS, VT, 1'b1, 64'd0,                   1'b0, 1'b1, 5'd2},  // R9 bad function
        '{4'd9,  mk(S3,0,2,7,1,6'b100000),  VS, VT, 1'b1, 64'd0,                   1'b0, 1'b1, 5'd7},  // R9 bad sa
        '{4'd1,  mk(6'b000000,1,2,7,4,6'b000000), VS, VT, 1'b1, 64'd0,             1'b0, 1'b1, 5'd2}   // R1 foreign opcode
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset res", res_q, 64'd0);
        chk("R12 reset flags", {62'd0, wr_en_q, rsvd_q}, 64'd0);
        chk("R12 reset dest", {59'd0, dest_q}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            instr    = VECS[i].ins;
            src_s    = VECS[i].s;
            src_t    = VECS[i].t;
            wide_en  = VECS[i].wide;
            @(negedge clk);
            op_valid = 1'b0;
            chk($sformatf("R%0d row%0d res", VECS[i].req, i), res_q, VECS[i].res);
            chk($sformatf("R%0d row%0d we/rsvd", VECS[i].req, i),
                {62'd0, wr_en_q, rsvd_q}, {62'd0, VECS[i].we, VECS[i].rsvd});
            if (VECS[i].we)
                chk($sformatf("R10 row%0d dest", i), {59'd0, dest_q}, {59'd0, VECS[i].dest});
        end

        // R11: one legal op, then idle cycles with changing inputs
        @(negedge clk);
        op_valid = 1'b1; instr = mk(S3,0,2,12,5,6'b100100); src_t = VT; wide_en = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; instr = mk(S3,1,3,7,0,6'b000000); src_s = VS; src_t = VB;
        held = res_q;
        chk("R11 issue result", held, 64'h3210_7654_BA98_FEDC);
        @(negedge clk);
        chk("R11 idle we/rsvd", {62'd0, wr_en_q, rsvd_q}, 64'd0);
        chk("R11 idle res hold", res_q, held);
        chk("R11 idle dest hold", {59'd0, dest_q}, 64'd12);

        // R12: reset while an op is issued clears everything
        op_valid = 1'b1; instr = mk(S3,1,2,31,0,6'b000000); rst_n = 1'b0;
        @(negedge clk);
        chk("R12 mid reset res", res_q, 64'd0);
        chk("R12 mid reset flags", {62'd0, wr_en_q, rsvd_q}, 64'd0);
        op_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule